// File: doc/BRIEF.md
# Front-End Sample and Control Link

This block sits between a DMT modem core and an external analog front end. It carries 16-bit samples in both directions as 4-bit nibbles. A free-running phase counter produces a word strobe at one quarter of the master clock rate. The strobe is high in the cycle that carries the most significant nibble of each sample. On the transmit side, the core offers a parallel word once per frame. On the receive side, the block rebuilds a parallel word from four nibbles and flags it with a one-cycle valid pulse.

A second, slower channel configures the front end. Each control transaction is a 16-bit full-duplex exchange that moves one bit per strobe cycle. A select line is held low for the whole transfer. The select pin and the control-read pin are shared with two general-purpose pins. A mode bit, cleared by reset, picks between the two functions, so after reset both pins serve general-purpose logic. Control requests made in that mode are refused with an error pulse. A separate active-low reset output keeps the front end held until the core releases it.

Top module: `afe_link`

## Requirements
- R1: `afe_strobe` is high in exactly one cycle out of every four. It is high in the first cycle after reset is released.
- R2: `tx_take` is high in the cycle just before each strobe cycle, and `tx_word` is captured at the end of that cycle. The captured word then appears on `afe_txd` over the next four cycles, most significant nibble first. Bits [15:12] are driven in the strobe cycle, and bits [3:0] are driven in the fourth cycle.
- R3: `afe_rxd` is sampled at each rising edge, and the nibble present during a strobe cycle becomes bits [15:12]. After the fourth nibble is sampled, `rx_word` holds the assembled word and `rx_valid` is high for one cycle. That cycle is the next strobe cycle.
- R4: An accepted control request raises `cw_busy` and drives `pad5_o` low with `pad5_oe` high. Both hold from the cycle after acceptance until the transfer ends.
- R5: During a transfer, `afe_cdout` presents `cw_wdata` most significant bit first, one bit per strobe cycle, for 16 strobe cycles. It changes only after a strobe-cycle edge. It is low when no transfer is running.
- R6: `pad4_i` is sampled at the end of each strobe cycle of a transfer. The first sampled bit becomes bit 15 of `cw_rdata`. In the cycle after the last bit, `cw_busy` is low and `cw_done` is high for one cycle.
- R7: `cw_req` is ignored while `cw_busy` is high. The running transfer continues unchanged, and no new transfer starts after it.
- R8: `cw_req` while the mode bit selects general-purpose use starts no transfer. It raises `cw_err` for one cycle in the next cycle.
- R9: The mode bit resets to 0 (general-purpose). It loads `mode_afe` when `mode_we` is high, unless a transfer is running. With mode 0, `pad5_o`/`pad5_oe` follow `gpio5_o`/`gpio5_oe` and `gpio4_i` follows `pad4_i`. With mode 1, `pad5_oe` is 1, `pad5_o` is the select level (1 when idle), and `gpio4_i` is 0.
- R10: `afe_rst_n` is low during reset and stays low after it. From then on it follows `afe_run` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write enable for the pin-function bit |
| mode_afe | input | 1 | New pin-function value (1 = front-end use) |
| afe_run | input | 1 | Release request for the front-end reset |
| tx_word | input | 16 | Transmit sample |
| tx_take | output | 1 | Transmit sample is captured at the end of this cycle |
| rx_word | output | 16 | Assembled receive sample |
| rx_valid | output | 1 | One-cycle pulse marking a new receive sample |
| cw_req | input | 1 | Control transfer request |
| cw_wdata | input | 16 | Control word to shift out |
| cw_busy | output | 1 | Control transfer in progress |
| cw_done | output | 1 | One-cycle pulse when a transfer ends |
| cw_rdata | output | 16 | Bits captured during the last transfer |
| cw_err | output | 1 | One-cycle pulse for a refused request |
| gpio5_o | input | 1 | General-purpose output value for the shared select pin |
| gpio5_oe | input | 1 | General-purpose output enable for the shared select pin |
| gpio4_i | output | 1 | General-purpose view of the shared read pin |
| afe_txd | output | 4 | Transmit nibble |
| afe_rxd | input | 4 | Receive nibble |
| afe_strobe | output | 1 | Word strobe, high on the first nibble |
| afe_cdout | output | 1 | Serial control data to the front end |
| pad5_o | output | 1 | Shared select / general-purpose pin value |
| pad5_oe | output | 1 | Shared select / general-purpose pin enable |
| pad4_i | input | 1 | Shared control-read / general-purpose pin |
| afe_rst_n | output | 1 | Active-low front-end reset |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the data. These are the four-cycle spacing of the strobe, the alignment of the receive pulse with the strobe, and the select pin held low for as long as a transfer is busy. They also check that the control output is steady between strobe edges, that it idles low, and that done and error pulses never overlap a busy transfer. Only the bench scenarios can show the data itself. This covers nibble order across a sweep of transmit and receive words, and the bit-exact control exchange. It also covers requests and mode writes being ignored mid-transfer, the refusal in general-purpose mode, the pin routing in both modes, and the timing of the reset release.

// File: rtl/afe_link_pkg.sv
package afe_link_pkg;

    localparam int unsigned NIB_W_DEF  = 4;
    localparam int unsigned SAMP_W_DEF = 16;
    localparam int unsigned CW_W_DEF   = 16;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    // drive pair for a shared bidirectional pad
    typedef struct packed {
        logic o;
        logic oe;
    } pad_drive_t;

    function automatic int unsigned frame_len(input int unsigned samp_w,
                                              input int unsigned nib_w);
        return samp_w / nib_w;
    endfunction

    function automatic pad_drive_t pick_pad(input logic use_afe,
                                            input pad_drive_t afe_side,
                                            input pad_drive_t gp_side);
        return use_afe ? afe_side : gp_side;
    endfunction

endpackage

// File: rtl/afe_phase_gen.sv
module afe_phase_gen #(
    parameter int unsigned NIB_CNT = 4
) (
    input  logic clk,
    input  logic rst,
    output logic strobe,
    output logic last
);
    localparam int unsigned PH_W = (NIB_CNT > 1) ? $clog2(NIB_CNT) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIB_CNT - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign strobe = (phase_q == '0);
    assign last   = (phase_q == PH_LAST);
endmodule

// File: rtl/afe_sample_path.sv
module afe_sample_path #(
    parameter int unsigned NIB_W  = 4,
    parameter int unsigned SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              last,
    input  logic [SAMP_W-1:0] tx_word,
    output logic [NIB_W-1:0]  txd,
    input  logic [NIB_W-1:0]  rxd,
    output logic [SAMP_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam int unsigned ACC_W = SAMP_W - NIB_W;

    logic [SAMP_W-1:0] tx_sh_q;
    logic [ACC_W-1:0]  rx_acc_q;
    logic [SAMP_W-1:0] rx_full;

    // transmit: load at frame end, shift one nibble per cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh_q <= '0;
        end else if (last) begin
            tx_sh_q <= tx_word;
        end else begin
            tx_sh_q <= tx_sh_q << NIB_W;
        end
    end

    assign txd = tx_sh_q[SAMP_W-1 -: NIB_W];

    // receive: sliding window of the newest nibbles
    assign rx_full = {rx_acc_q, rxd};

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_acc_q <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_acc_q <= rx_full[ACC_W-1:0];
            rx_valid <= last;
            if (last) begin
                rx_word <= rx_full;
            end
        end
    end
endmodule

// File: rtl/afe_ctl_shifter.sv
module afe_ctl_shifter
    import afe_link_pkg::*;
#(
    parameter int unsigned CW_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    input  logic            start,
    input  logic [CW_W-1:0] wdata,
    input  logic            din,
    output logic            dout,
    output logic            busy,
    output logic            done,
    output logic [CW_W-1:0] rdata
);
    localparam int unsigned BC_W = $clog2(CW_W);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(CW_W - 1);

    ctl_state_e      state_q;
    logic [CW_W-1:0] out_sh_q;
    logic [CW_W-2:0] in_sh_q;
    logic [BC_W-1:0] bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CTL_IDLE;
            out_sh_q <= '0;
            in_sh_q  <= '0;
            bit_q    <= '0;
            done     <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                CTL_IDLE: begin
                    if (start) begin
                        out_sh_q <= wdata;
                        bit_q    <= '0;
                        state_q  <= CTL_RUN;
                    end
                end
                CTL_RUN: begin
                    if (strobe) begin
                        out_sh_q <= out_sh_q << 1;
                        in_sh_q  <= {in_sh_q[CW_W-3:0], din};
                        if (bit_q == BC_LAST) begin
                            state_q <= CTL_IDLE;
                            done    <= 1'b1;
                            rdata   <= {in_sh_q, din};
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    assign busy = (state_q == CTL_RUN);
    assign dout = busy & out_sh_q[CW_W-1];
endmodule

// File: rtl/afe_link.sv
module afe_link
    import afe_link_pkg::*;
#(
    parameter int unsigned NIB_W  = NIB_W_DEF,
    parameter int unsigned SAMP_W = SAMP_W_DEF,
    parameter int unsigned CW_W   = CW_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic              mode_afe,
    input  logic              afe_run,
    input  logic [SAMP_W-1:0] tx_word,
    output logic              tx_take,
    output logic [SAMP_W-1:0] rx_word,
    output logic              rx_valid,
    input  logic              cw_req,
    input  logic [CW_W-1:0]   cw_wdata,
    output logic              cw_busy,
    output logic              cw_done,
    output logic [CW_W-1:0]   cw_rdata,
    output logic              cw_err,
    input  logic              gpio5_o,
    input  logic              gpio5_oe,
    output logic              gpio4_i,
    output logic [NIB_W-1:0]  afe_txd,
    input  logic [NIB_W-1:0]  afe_rxd,
    output logic              afe_strobe,
    output logic              afe_cdout,
    output logic              pad5_o,
    output logic              pad5_oe,
    input  logic              pad4_i,
    output logic              afe_rst_n
);
    localparam int unsigned NIB_CNT = frame_len(SAMP_W, NIB_W);

    logic       frame_last;
    logic       mode_q;
    logic       start;
    pad_drive_t pad5_drv;

    afe_phase_gen #(.NIB_CNT(NIB_CNT)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .strobe (afe_strobe),
        .last   (frame_last)
    );

    afe_sample_path #(.NIB_W(NIB_W), .SAMP_W(SAMP_W)) u_samples (
        .clk      (clk),
        .rst      (rst),
        .last     (frame_last),
        .tx_word  (tx_word),
        .txd      (afe_txd),
        .rxd      (afe_rxd),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    assign tx_take = frame_last;
    assign start   = cw_req & mode_q & ~cw_busy;

    afe_ctl_shifter #(.CW_W(CW_W)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .strobe (afe_strobe),
        .start  (start),
        .wdata  (cw_wdata),
        .din    (pad4_i),
        .dout   (afe_cdout),
        .busy   (cw_busy),
        .done   (cw_done),
        .rdata  (cw_rdata)
    );

    // pin function bit, error pulse, front-end reset
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= 1'b0;
            cw_err    <= 1'b0;
            afe_rst_n <= 1'b0;
        end else begin
            if (mode_we && !cw_busy) begin
                mode_q <= mode_afe;
            end
            cw_err    <= cw_req & ~mode_q;
            afe_rst_n <= afe_run;
        end
    end

    assign pad5_drv = pick_pad(mode_q,
                               '{o: ~cw_busy, oe: 1'b1},
                               '{o: gpio5_o, oe: gpio5_oe});
    assign pad5_o   = pad5_drv.o;
    assign pad5_oe  = pad5_drv.oe;
    assign gpio4_i  = pad4_i & ~mode_q;
endmodule

// File: rtl/afe_link_chk.sv
module afe_link_chk #(
    parameter int unsigned NIB_CNT = 4
) (
    input logic clk,
    input logic rst,
    input logic afe_strobe,
    input logic rx_valid,
    input logic cw_busy,
    input logic cw_done,
    input logic cw_err,
    input logic afe_cdout,
    input logic pad5_o,
    input logic pad5_oe,
    input logic afe_rst_n
);
    localparam int unsigned GAP_W = $clog2(NIB_CNT) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (afe_strobe) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1: strobe returns after exactly NIB_CNT-1 quiet cycles
    p_strobe_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (seen_q && afe_strobe) |-> (gap_q == GAP_W'(NIB_CNT - 1)));
    p_strobe_max_r1: assert property (@(posedge clk) disable iff (rst)
        !afe_strobe |-> (gap_q < GAP_W'(NIB_CNT - 1)));
    p_valid_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> afe_strobe);
    p_sel_low_r4: assert property (@(posedge clk) disable iff (rst)
        cw_busy |-> (pad5_oe && !pad5_o));
    p_cdout_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (cw_busy && $past(cw_busy) && !$past(afe_strobe)) |-> $stable(afe_cdout));
    p_cdout_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !cw_busy |-> !afe_cdout);
    p_done_end_r6: assert property (@(posedge clk) disable iff (rst)
        cw_done |-> (!cw_busy && $past(cw_busy)));
    p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
        cw_err |-> !cw_busy);
    p_rst_hold_r10: assert property (@(posedge clk)
        rst |=> !afe_rst_n);
endmodule

bind afe_link afe_link_chk #(.NIB_CNT(NIB_CNT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .afe_strobe (afe_strobe),
    .rx_valid   (rx_valid),
    .cw_busy    (cw_busy),
    .cw_done    (cw_done),
    .cw_err     (cw_err),
    .afe_cdout  (afe_cdout),
    .pad5_o     (pad5_o),
    .pad5_oe    (pad5_oe),
    .afe_rst_n  (afe_rst_n)
);

// File: tb/afe_link_tb.sv
`timescale 1ns/1ps
module afe_link_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0, mode_afe = 1'b0, afe_run = 1'b0;
    logic [15:0] tx_word = '0;
    logic        tx_take;
    logic [15:0] rx_word;
    logic        rx_valid;
    logic        cw_req = 1'b0;
    logic [15:0] cw_wdata = '0;
    logic        cw_busy, cw_done, cw_err;
    logic [15:0] cw_rdata;
    logic        gpio5_o = 1'b1, gpio5_oe = 1'b1;
    logic        gpio4_i;
    logic [3:0]  afe_txd;
    logic [3:0]  afe_rxd = '0;
    logic        afe_strobe, afe_cdout, pad5_o, pad5_oe;
    logic        pad4_i = 1'b0;
    logic        afe_rst_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    afe_link u_dut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_afe(mode_afe),
        .afe_run(afe_run), .tx_word(tx_word), .tx_take(tx_take),
        .rx_word(rx_word), .rx_valid(rx_valid), .cw_req(cw_req),
        .cw_wdata(cw_wdata), .cw_busy(cw_busy), .cw_done(cw_done),
        .cw_rdata(cw_rdata), .cw_err(cw_err), .gpio5_o(gpio5_o),
        .gpio5_oe(gpio5_oe), .gpio4_i(gpio4_i), .afe_txd(afe_txd),
        .afe_rxd(afe_rxd), .afe_strobe(afe_strobe), .afe_cdout(afe_cdout),
        .pad5_o(pad5_o), .pad5_oe(pad5_oe), .pad4_i(pad4_i),
        .afe_rst_n(afe_rst_n)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctl_xfer(input logic [15:0] w, input logic [15:0] rd, input bit poke);
        int  nbit = 0;
        bit  sel_ok = 1'b1;
        bit  dat_ok = 1'b1;
        int  guard = 0;
        cw_wdata = w;
        cw_req   = 1'b1;
        @(negedge clk);
        cw_req = 1'b0;
        check(cw_busy && pad5_oe && !pad5_o, "R4 select low after accept",
              {cw_busy, pad5_oe, pad5_o}, 3'b110);
        while (cw_busy && guard < 200) begin
            guard++;
            if (!(pad5_oe && !pad5_o)) sel_ok = 1'b0;
            if (afe_strobe) begin
                if (nbit > 15 || afe_cdout != w[15 - nbit]) dat_ok = 1'b0;
                if (nbit <= 15) pad4_i = rd[15 - nbit];
                nbit++;
            end
            if (poke && nbit == 5 && !afe_strobe) begin
                cw_req   = 1'b1;
                cw_wdata = ~w;
                mode_we  = 1'b1;
                mode_afe = 1'b0;
            end else begin
                cw_req   = 1'b0;
                mode_we  = 1'b0;
            end
            @(negedge clk);
        end
        cw_req  = 1'b0;
        mode_we = 1'b0;
        check(sel_ok, "R4 select held low for whole transfer", sel_ok, 1);
        check(dat_ok, "R5 control bits MSB first per strobe", dat_ok, 1);
        check(nbit == 16, "R5 sixteen strobe bits", nbit, 16);
        check(!cw_busy && cw_done, "R6 done pulse after last bit",
              {cw_busy, cw_done}, 2'b01);
        check(cw_rdata == rd, "R6 read data", cw_rdata, rd);
        check(!afe_cdout, "R5 data idle low", afe_cdout, 0);
        @(negedge clk);
        check(!cw_busy && !cw_done, "R7 no restart, done one cycle",
              {cw_busy, cw_done}, 2'b00);
        check(pad5_oe && pad5_o, "R9 front-end mode kept, select idle high",
              {pad5_oe, pad5_o}, 2'b11);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] prev_r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state, R1 / R10 / R9
        check(afe_strobe, "R1 strobe in first cycle", afe_strobe, 1);
        check(!afe_rst_n, "R10 front-end held in reset", afe_rst_n, 0);
        check(!cw_busy && !rx_valid && !cw_err, "R6 idle after reset",
              {cw_busy, rx_valid, cw_err}, 0);
        check(pad5_o == gpio5_o && pad5_oe == gpio5_oe, "R9 pad follows gpio at reset",
              {pad5_o, pad5_oe}, {gpio5_o, gpio5_oe});
        for (int n = 1; n < 40; n++) begin
            @(negedge clk);
            check(afe_strobe == ((n % 4) == 0), "R1 strobe period", afe_strobe, (n % 4) == 0);
        end

        // transmit / receive sweep, R2 R3
        while (!tx_take) @(negedge clk);
        prev_r = '0;
        for (int i = 0; i < 64; i++) begin
            logic [15:0] w;
            logic [15:0] r;
            w = (i == 63) ? 16'hFFFF : (16'(i * 16'h1357) ^ 16'(i << 9));
            r = 16'(i * 16'h2F1B + 16'h00C3);
            tx_word = w;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                check(afe_txd == w[15 - 4*k -: 4] && afe_strobe == (k == 0),
                      "R2 transmit nibble order", {afe_strobe, afe_txd},
                      {(k == 0), w[15 - 4*k -: 4]});
                if (k == 0 && i > 0)
                    check(rx_valid && rx_word == prev_r, "R3 receive word",
                          {rx_valid, rx_word}, {1'b1, prev_r});
                if (k == 1)
                    check(!rx_valid, "R3 valid one cycle", rx_valid, 0);
                if (k == 3)
                    check(tx_take, "R2 take before strobe", tx_take, 1);
                afe_rxd = r[15 - 4*k -: 4];
            end
            prev_r = r;
        end
        @(negedge clk);
        check(rx_valid && rx_word == prev_r, "R3 final receive word",
              {rx_valid, rx_word}, {1'b1, prev_r});

        // general-purpose mode: routing and refusal, R8 R9
        gpio5_o = 1'b0; gpio5_oe = 1'b1; pad4_i = 1'b1;
        #0;
        @(negedge clk);
        check(pad5_o == 1'b0 && pad5_oe && gpio4_i, "R9 gpio routing",
              {pad5_o, pad5_oe, gpio4_i}, 3'b011);
        cw_wdata = 16'h1234;
        cw_req   = 1'b1;
        @(negedge clk);
        cw_req = 1'b0;
        check(cw_err && !cw_busy, "R8 refused in gpio mode", {cw_err, cw_busy}, 2'b10);
        @(negedge clk);
        check(!cw_err && !cw_busy, "R8 error one cycle, nothing started",
              {cw_err, cw_busy}, 2'b00);

        // switch to front-end mode
        mode_afe = 1'b1; mode_we = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
        gpio5_oe = 1'b0;
        @(negedge clk);
        check(pad5_oe && pad5_o && !gpio4_i, "R9 front-end routing",
              {pad5_oe, pad5_o, gpio4_i}, 3'b110);

        // control transfers, R4 R5 R6 R7
        ctl_xfer(16'hA5C3, 16'h3C5A, 1'b0);
        ctl_xfer(16'hFFFF, 16'h0000, 1'b0);
        ctl_xfer(16'h8000, 16'h0001, 1'b1);
        for (int j = 0; j < 6; j++) begin
            ctl_xfer(16'(j * 16'h4B1D + 16'h0007), 16'(16'hF00F ^ (j * 16'h0923)), (j == 2));
            repeat (j) @(negedge clk);
        end

        // back to general-purpose
        mode_afe = 1'b0; mode_we = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
        gpio5_o = 1'b1; gpio5_oe = 1'b0;
        @(negedge clk);
        check(pad5_o && !pad5_oe, "R9 returns to gpio", {pad5_o, pad5_oe}, 2'b10);

        // front-end reset release, R10
        check(!afe_rst_n, "R10 still held", afe_rst_n, 0);
        afe_run = 1'b1;
        @(negedge clk);
        check(afe_rst_n, "R10 released one cycle later", afe_rst_n, 1);
        afe_run = 1'b0;
        @(negedge clk);
        check(!afe_rst_n, "R10 follows run", afe_rst_n, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule